// File: doc/BRIEF.md
# Multi-Mode Timer Output Compare

This block pairs a free-running up-counter with a compare stage that drives one output pin. A 3-bit mode selects one of eight pin behaviours: pass-through of a general-purpose level, two single-shot edges, toggle, a delayed single pulse, a repeating pulse, and pulse-width modulation with or without a fault shutdown. Every mode sets its own pin level when it is written, raises a one-cycle interrupt flag on its own events, and decides whether a period match clears the counter.

A mode is written with a strobe. The write takes effect only while the counter is stopped, so software stops the counter, writes the mode and compare values, then restarts it. Compare value `cmp_r` is used as it arrives. In the modulation modes `cmp_rs` passes through a shadow register that reloads only at a period boundary.

Top module: `ocmp_unit`

## Requirements
- R1: A mode write (`mode_wr` high) is taken only in a cycle where `tmr_en` is low. A write while `tmr_en` is high has no effect.
- R2: In mode 000 `pin_out` follows `gpio_val` in the same cycle, and `irq` stays low.
- R3: Writing mode 001 sets the pin to 0. The first counter value equal to `cmp_r` sets it to 1 at the next edge, with `irq` high for that one cycle. Later matches do nothing until the mode is written again.
- R4: Writing mode 010 sets the pin to 1. The first match with `cmp_r` drives it to 0 once, and `irq` pulses on that falling edge.
- R5: Writing mode 011 keeps the level the pin showed at the write. Every match with `cmp_r` inverts the pin, and `irq` pulses on each inversion.
- R6: Writing mode 100 sets the pin to 0. A match with `cmp_r` drives it high, and the next match with `cmp_rs` drives it low. This happens once, with `irq` pulsing on the fall.
- R7: Mode 101 behaves like mode 100 but re-arms after each fall, so the high/low pair repeats on every counter wrap.
- R8: Writing mode 110 or 111 sets the pin to 1 if `cmp_r` is non-zero and to 0 if it is zero.
- R9: In modes 110 and 111 a period match (counter equal to `period`) sets the pin high and reloads the shadow of `cmp_rs`. Otherwise a match with the shadow value drives the pin low. The period match wins when both coincide. Mode 110 never raises `irq`.
- R10: `per_reset` is high while `tmr_en` is high, the mode is 110 or 111 and the counter equals `period`; the counter then reads 0 after the edge. In all other modes the counter wraps only at its all-ones value.
- R11: In mode 111 a low `fault_n` forces the pin to 0 from the next edge and latches until the mode is written again. `irq` pulses on each falling edge of `fault_n`.
- R12: The counter resets to 0, advances by one per cycle while `tmr_en` is high, and holds while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Counter run enable; mode writes need it low |
| period | input | W | Period value for the modulation modes |
| cmp_r | input | W | Primary compare value |
| cmp_rs | input | W | Secondary compare value (shadowed in the modulation modes) |
| mode | input | 3 | Mode value to write |
| mode_wr | input | 1 | Mode write strobe |
| gpio_val | input | 1 | Pin level used in mode 000 |
| fault_n | input | 1 | Active-low fault for mode 111 |
| pin_out | output | 1 | Compare output pin |
| irq | output | 1 | One-cycle interrupt flag |
| tmr_val | output | W | Current counter value |
| per_reset | output | 1 | Period-match counter reset request |

## Verification
In the modulation modes the period match and the secondary match can fall in the same cycle when the shadow value equals `period`. The pin must then go high, not low. A fault edge can also land on a period boundary, where the pin must stay forced low while `irq` still pulses. The random stimulus draws `cmp_rs` from a range that reaches `period` and past it, and drops `fault_n` at random cycles. A directed segment sets the two values equal. Each cycle the pin, flag, counter and reset request are compared against a bench model built from the requirements.

// File: rtl/ocmp_unit.sv
module ocmp_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tmr_en,
  input  logic [W-1:0] period,
  input  logic [W-1:0] cmp_r,
  input  logic [W-1:0] cmp_rs,
  input  logic [2:0]   mode,
  input  logic         mode_wr,
  input  logic         gpio_val,
  input  logic         fault_n,
  output logic         pin_out,
  output logic         irq,
  output logic [W-1:0] tmr_val,
  output logic         per_reset
);
  localparam logic [2:0] M_OFF = 3'd0, M_LOSHOT = 3'd1, M_HISHOT = 3'd2, M_TOG = 3'd3,
                         M_DLY = 3'd4, M_CONT = 3'd5, M_PWM = 3'd6, M_PWMF = 3'd7;

  logic [2:0]   mode_q;
  logic [W-1:0] tmr_q, rs_q, rs_d;
  logic         pin_q, pin_d, arm_q, arm_d, stg_q, stg_d, flt_q, flt_d, fd_q, irq_q, irq_d;
  logic         take_wr, pwm_q, hit_r, hit_rs, hit_sh, rise, fall;

  assign take_wr   = mode_wr && !tmr_en;
  assign pwm_q     = (mode_q == M_PWM) || (mode_q == M_PWMF);
  assign hit_r     = (tmr_q == cmp_r);
  assign hit_rs    = (tmr_q == cmp_rs);
  assign hit_sh    = (tmr_q == rs_q);
  assign per_reset = tmr_en && pwm_q && (tmr_q == period);
  assign pin_out   = (mode_q == M_OFF) ? gpio_val : pin_q;
  assign tmr_val   = tmr_q;
  assign irq       = irq_q;
  assign rise      = !pin_q && pin_d;
  assign fall      = pin_q && !pin_d;

  always_comb begin
    pin_d = pin_q;
    arm_d = arm_q;
    stg_d = stg_q;
    flt_d = flt_q;
    rs_d  = rs_q;
    irq_d = 1'b0;
    if (take_wr) begin
      flt_d = 1'b0;
      case (mode)
        M_LOSHOT:      begin pin_d = 1'b0; arm_d = 1'b1; end
        M_HISHOT:      begin pin_d = 1'b1; arm_d = 1'b1; end
        M_TOG:         pin_d = pin_out;
        M_DLY, M_CONT: begin pin_d = 1'b0; arm_d = 1'b1; stg_d = 1'b0; end
        M_PWM, M_PWMF: begin pin_d = (cmp_r != '0); rs_d = cmp_rs; end
        default:       ;
      endcase
    end else begin
      if (tmr_en) begin
        case (mode_q)
          M_LOSHOT: if (arm_q && hit_r) begin pin_d = 1'b1; arm_d = 1'b0; end
          M_HISHOT: if (arm_q && hit_r) begin pin_d = 1'b0; arm_d = 1'b0; end
          M_TOG:    if (hit_r) pin_d = !pin_q;
          M_DLY, M_CONT:
            if (arm_q) begin
              if (!stg_q && hit_r) begin
                pin_d = 1'b1;
                stg_d = 1'b1;
              end else if (stg_q && hit_rs) begin
                pin_d = 1'b0;
                stg_d = 1'b0;
                arm_d = (mode_q == M_CONT);
              end
            end
          M_PWM, M_PWMF:
            if (per_reset) begin
              pin_d = 1'b1;
              rs_d  = cmp_rs;
            end else if (hit_sh) begin
              pin_d = 1'b0;
            end
          default: ;
        endcase
      end
      if (mode_q == M_PWMF && !fault_n) flt_d = 1'b1;
      if (mode_q == M_PWMF && flt_d) pin_d = 1'b0;
      case (mode_q)
        M_LOSHOT:      irq_d = rise;
        M_HISHOT:      irq_d = fall;
        M_TOG:         irq_d = rise || fall;
        M_DLY, M_CONT: irq_d = fall;
        M_PWMF:        irq_d = fd_q && !fault_n;
        default:       irq_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_OFF;
      tmr_q  <= '0;
      rs_q   <= '0;
      pin_q  <= 1'b0;
      arm_q  <= 1'b0;
      stg_q  <= 1'b0;
      flt_q  <= 1'b0;
      fd_q   <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      if (take_wr) mode_q <= mode;
      if (tmr_en) tmr_q <= per_reset ? '0 : tmr_q + 1'b1;
      rs_q  <= rs_d;
      pin_q <= pin_d;
      arm_q <= arm_d;
      stg_q <= stg_d;
      flt_q <= flt_d;
      fd_q  <= fault_n;
      irq_q <= irq_d;
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) tmr_en |=> $stable(mode_q)); // R1
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == M_OFF) |-> !irq); // R2
  AST_SHOT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_LOSHOT && pin_q && !mode_wr) |=> pin_q); // R3
  AST_PWM_NOIRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PWM && !mode_wr) |=> !irq); // R9
  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en && !pwm_q) |=> tmr_q == $past(tmr_q) + 1'b1); // R10
  AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PWMF && flt_q && !mode_wr) |=> !pin_out); // R11
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tmr_en |=> $stable(tmr_q)); // R12
endmodule

// File: tb/ocmp_unit_test.sv
`timescale 1ns/1ps
module ocmp_unit_test;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0, tmr_en = 1'b0, mode_wr = 1'b0, gpio_val = 1'b1, fault_n = 1'b1;
  logic [W-1:0] period = '0, cmp_r = '0, cmp_rs = '0;
  logic [2:0] mode = '0;
  logic pin_out, irq, per_reset;
  logic [W-1:0] tmr_val;
  int checks = 0, bad = 0;

  logic [2:0] m_mode = '0;
  logic [W-1:0] m_tmr = '0, m_rs = '0;
  logic m_pin = 0, m_arm = 0, m_stg = 0, m_flt = 0, m_fd = 1, m_irq = 0;

  ocmp_unit #(.W(W)) uut (.clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .period(period), .cmp_r(cmp_r),
    .cmp_rs(cmp_rs), .mode(mode), .mode_wr(mode_wr), .gpio_val(gpio_val), .fault_n(fault_n),
    .pin_out(pin_out), .irq(irq), .tmr_val(tmr_val), .per_reset(per_reset));

  always #2.5 clk = ~clk;

  function automatic logic exp_pin();
    return (m_mode == 3'd0) ? gpio_val : m_pin;
  endfunction
  function automatic logic exp_per();
    return tmr_en && m_mode[2] && m_mode[1] && (m_tmr == period);
  endfunction
  function automatic string tag_of(logic [2:0] md);
    case (md)
      3'd0: return "R2"; 3'd1: return "R3"; 3'd2: return "R4"; 3'd3: return "R5";
      3'd4: return "R6"; 3'd5: return "R7"; 3'd6: return "R9"; default: return "R11";
    endcase
  endfunction

  task automatic check(input logic [W+2:0] act, input logic [W+2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s {pin,irq,per,tmr} actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic np, ni, per;
    np = m_pin; ni = 1'b0; per = exp_per();
    if (mode_wr && !tmr_en) begin
      m_flt = 1'b0;
      case (mode)
        3'd1: begin np = 1'b0; m_arm = 1'b1; end
        3'd2: begin np = 1'b1; m_arm = 1'b1; end
        3'd3: np = exp_pin();
        3'd4, 3'd5: begin np = 1'b0; m_arm = 1'b1; m_stg = 1'b0; end
        3'd6, 3'd7: begin np = (cmp_r != 0); m_rs = cmp_rs; end
        default: ;
      endcase
      m_mode = mode;
    end else begin
      if (tmr_en) begin
        if ((m_mode == 3'd1 || m_mode == 3'd2) && m_arm && m_tmr == cmp_r) begin
          np = (m_mode == 3'd1); m_arm = 1'b0;
        end
        if (m_mode == 3'd3 && m_tmr == cmp_r) np = !m_pin;
        if ((m_mode == 3'd4 || m_mode == 3'd5) && m_arm) begin
          if (!m_stg && m_tmr == cmp_r) begin np = 1'b1; m_stg = 1'b1; end
          else if (m_stg && m_tmr == cmp_rs) begin np = 1'b0; m_stg = 1'b0; m_arm = (m_mode == 3'd5); end
        end
        if (m_mode >= 3'd6) begin
          if (per) begin np = 1'b1; m_rs = cmp_rs; end
          else if (m_tmr == m_rs) np = 1'b0;
        end
      end
      if (m_mode == 3'd7 && !fault_n) m_flt = 1'b1;
      if (m_mode == 3'd7 && m_flt) np = 1'b0;
      case (m_mode)
        3'd1: ni = !m_pin && np;
        3'd2, 3'd4, 3'd5: ni = m_pin && !np;
        3'd3: ni = m_pin != np;
        3'd7: ni = m_fd && !fault_n;
        default: ni = 1'b0;
      endcase
    end
    if (tmr_en) m_tmr = per ? '0 : m_tmr + 1'b1;
    m_pin = np; m_irq = ni; m_fd = fault_n;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({pin_out, irq, per_reset, tmr_val}, {exp_pin(), m_irq, exp_per(), m_tmr}, tag_of(m_mode));
  endtask

  task automatic write_mode(input logic [2:0] md);
    tmr_en = 1'b0; mode = md; mode_wr = 1'b1; step(); mode_wr = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check({pin_out, irq, per_reset, tmr_val}, {1'b1, 1'b0, 1'b0, 8'd0}, "R12 reset"); // R2 pin follows gpio
    rst_n = 1'b1;

    // R1: write while running is ignored
    tmr_en = 1'b1; mode = 3'd2; mode_wr = 1'b1; step(); mode_wr = 1'b0;
    gpio_val = 1'b0; step();
    check({pin_out, irq}, {1'b0, 1'b0}, "R1 write under tmr_en");

    // R3 directed: cmp_r = 20
    cmp_r = 8'd20; write_mode(3'd1);
    tmr_en = 1'b1;
    while (tmr_val != 8'd20) step();
    check({pin_out, irq}, 2'b00, "R3 before match");
    step();
    check({pin_out, irq}, 2'b11, "R3 rise with irq");
    step();
    check({pin_out, irq}, 2'b10, "R3 irq one cycle");

    // R12 hold while disabled
    tmr_en = 1'b0;
    begin
      logic [W-1:0] held;
      held = tmr_val;
      repeat (4) step();
      check({3'b000, tmr_val}, {3'b000, held}, "R12 counter holds");
    end

    // R8 initial levels
    cmp_r = 8'd0; write_mode(3'd6);
    check({2'b00, pin_out}, 3'b000, "R8 zero cmp_r gives 0");
    cmp_r = 8'd3; write_mode(3'd7);
    check({2'b00, pin_out}, 3'b001, "R8 non-zero cmp_r gives 1");

    // R10 and R9 directed: period 9, shadow equal to period
    period = 8'd9; cmp_rs = 8'd9; write_mode(3'd6);
    tmr_en = 1'b1;
    while (tmr_val != 8'd9) step();
    check({2'b00, per_reset}, 3'b001, "R10 per_reset at match");
    step();
    check({pin_out, 2'b00, tmr_val}, {1'b1, 2'b00, 8'd0}, "R10 cleared, R9 period wins");
    repeat (30) step();
    write_mode(3'd3);
    tmr_en = 1'b1;
    while (tmr_val != 8'd9) step();
    step();
    check({3'b000, tmr_val}, {3'b000, 8'd10}, "R10 no clear outside modulation");

    for (int s = 0; s < 60; s++) begin
      period = 8'($urandom_range(4, 60));
      cmp_r  = 8'($urandom_range(0, 62));
      cmp_rs = 8'($urandom_range(0, 62));
      gpio_val = 1'($urandom);
      fault_n = 1'b1;
      write_mode(3'($urandom));
      tmr_en = 1'b1;
      for (int c = 0; c < 600; c++) begin
        if ($urandom_range(0, 63) == 0) fault_n = !fault_n;
        if ($urandom_range(0, 99) == 0) cmp_rs = 8'($urandom_range(0, 62));
        if ($urandom_range(0, 199) == 0) gpio_val = !gpio_val;
        mode_wr = ($urandom_range(0, 149) == 0);
        mode = 3'($urandom);
        if ($urandom_range(0, 299) == 0) tmr_en = 1'b0;
        step();
        mode_wr = 1'b0; tmr_en = 1'b1;
      end
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule